// File: doc/BRIEF.md
# Clock Ratio and Sync Monitor

This block sits in the system clock domain of an audio converter datapath. It takes a word clock that has already been synchronized into that domain. It measures how many system clocks fit into one word-clock period and reports which oversampling ratio is in use. Until a stable ratio has been seen twice in a row, it tells the datapath to hold its output at midscale.

After reset is released, a fixed-length initialization window runs first, and the block reports itself not ready until that window ends. Once lock is held, every word-clock rising edge is compared with the period the locked ratio predicts. The allowed deviation is a number of bit clocks, converted into system clocks from the locked ratio. A larger deviation, or a word clock that stops, drops lock, restarts initialization and raises the force-to-midscale request. The request stays up until the monitor is both ready and locked again.

Top module: `clk_ratio_sync_mon`

## Requirements
- R1: A measured period (system clocks between two word-clock rising edges) classifies as code 0, 1, 2, 3, 4 or 5 when it lies within ±CLS_TOL (default 8) of 128, 192, 256, 384, 512 or 768 respectively. Any other period classifies as code 7 (invalid).
- R2: Lock is declared at the word-clock edge that ends the second of two consecutive periods with the same valid code. While locked, `ratio_code` holds that code. While unlocked, it reads 7.
- R3: After reset release, `sys_ready` stays low for exactly INIT_CYCLES (default 1024) rising clock edges and is high after the last of them.
- R4: `force_midscale` is high in every cycle in which the block is not ready or not locked, and low otherwise.
- R5: While locked, a measured period that differs from the locked ratio by more than DRIFT_BCK×ratio/BCK_PER_WORD system clocks (default 6×ratio/64) drops lock and restarts the initialization window in the cycle after that edge.
- R6: While locked, a measured period that differs from the locked ratio by no more than that threshold keeps lock and the code. This holds even when the period is outside the R1 classification window.
- R7: If no word-clock rising edge arrives for TIMEOUT (default 960) cycles, lock is dropped. If the block was locked, initialization also restarts. The edge that follows the silence starts a new measurement and does not count as a period.
- R8: While reset is asserted, `ratio_code` is 7, `sys_ready` and `ratio_lock` are low, and `force_midscale` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset |
| word_clk | input | 1 | Word clock, already synchronized to sys_clk |
| ratio_code | output | 3 | Locked ratio code 0..5, or 7 when unlocked |
| sys_ready | output | 1 | Initialization window finished |
| ratio_lock | output | 1 | Ratio locked and phase within window |
| force_midscale | output | 1 | Request to hold the analog path at bipolar zero |

## Verification
A corrupted period counter or lock state shows up at the ports one cycle after the next word-clock rising edge. It appears as a wrong `ratio_code`, a lock that rises one period too early or too late, or a lock that should have dropped. A wrong initialization count is seen as `sys_ready` rising on the wrong edge, so the bench compares all four outputs against a behavioural model on every clock. The scenarios cover the exact threshold boundary (deviation equal to and one above the limit), both edges of the classification window, every legal ratio, and a stopped word clock.

// File: rtl/ratio_mon_pkg.sv
package ratio_mon_pkg;

  localparam int NUM_RATIOS = 6;
  localparam int CODE_W     = 3;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CODE_NONE = code_t'(7);

  // Ratios ascend as 2u, 3u, 4u, 6u, 8u, 12u for a unit u.
  function automatic int ratio_of(input int idx, input int unit_clks);
    int mult;
    mult = (idx % 2 == 0) ? 2 : 3;
    return mult * (unit_clks << (idx / 2));
  endfunction

endpackage

// File: rtl/rm_init_seq.sv
module rm_init_seq #(
  parameter int INIT_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic ready_o
);

  localparam int IW = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
  localparam logic [IW-1:0] LAST = IW'(INIT_CYCLES - 1);

  logic [IW-1:0] cnt_q, cnt_d;
  logic          ready_q, ready_d;

  always_comb begin
    cnt_d   = cnt_q;
    ready_d = ready_q;
    if (restart_i) begin
      cnt_d   = '0;
      ready_d = 1'b0;
    end else if (!ready_q) begin
      if (cnt_q == LAST) ready_d = 1'b1;
      else               cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ready_q <= ready_d;
    end
  end

  assign ready_o = ready_q;

  // R3: ready cannot appear before the window has been counted out
  a_r3_no_early_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_q && cnt_q != LAST) |=> !ready_q);

  // R5: a restart request always ends in a not-ready state
  a_r5_restart_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !ready_o);

endmodule

// File: rtl/rm_period_meter.sv
module rm_period_meter #(
  parameter int TIMEOUT = 960,
  parameter int CNT_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wclk_i,
  output logic             rise_o,
  output logic [CNT_W-1:0] meas_o,
  output logic             timeout_o
);

  localparam logic [CNT_W-1:0] TMO = CNT_W'(TIMEOUT);

  logic             wclk_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rise;

  assign rise = wclk_i & ~wclk_q;

  always_comb begin
    cnt_d = cnt_q;
    if (rise)              cnt_d = '0;
    else if (cnt_q != TMO) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wclk_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      wclk_q <= wclk_i;
      cnt_q  <= cnt_d;
    end
  end

  assign rise_o    = rise;
  assign meas_o    = cnt_q + 1'b1;
  assign timeout_o = (cnt_q == TMO) && !rise;

  // R7: the counter restarts at every rising edge of the word clock
  a_r7_count_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (meas_o == CNT_W'(1)));

endmodule

// File: rtl/rm_ratio_class.sv
module rm_ratio_class
  import ratio_mon_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int RATIO_UNIT = 64,
  parameter int CLS_TOL    = 8
) (
  input  logic [CNT_W-1:0] meas_i,
  output code_t            code_o
);

  logic [NUM_RATIOS-1:0] hit;

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
    localparam int R = ratio_of(g, RATIO_UNIT);
    assign hit[g] = (int'(meas_i) >= R - CLS_TOL) && (int'(meas_i) <= R + CLS_TOL);
  end

  always_comb begin
    code_o = CODE_NONE;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (hit[i]) code_o = code_t'(i);
    end
  end

endmodule

// File: rtl/clk_ratio_sync_mon.sv
module clk_ratio_sync_mon
  import ratio_mon_pkg::*;
#(
  parameter int INIT_CYCLES  = 1024,
  parameter int RATIO_UNIT   = 64,
  parameter int CLS_TOL      = 8,
  parameter int DRIFT_BCK    = 6,
  parameter int BCK_PER_WORD = 64,
  parameter int TIMEOUT      = 960
) (
  input  logic       sys_clk,
  input  logic       sys_rst_n,
  input  logic       word_clk,
  output logic [2:0] ratio_code,
  output logic       sys_ready,
  output logic       ratio_lock,
  output logic       force_midscale
);

  localparam int CNT_W     = $clog2(TIMEOUT + 2);
  localparam int NUM_SLOTS = 1 << CODE_W;

  logic             rise, timeout;
  logic [CNT_W-1:0] meas;
  code_t            cls;
  logic             restart;
  logic             ready;

  rm_period_meter #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_meter (
    .clk(sys_clk), .rst_n(sys_rst_n), .wclk_i(word_clk),
    .rise_o(rise), .meas_o(meas), .timeout_o(timeout)
  );

  rm_ratio_class #(.CNT_W(CNT_W), .RATIO_UNIT(RATIO_UNIT), .CLS_TOL(CLS_TOL)) u_class (
    .meas_i(meas), .code_o(cls)
  );

  rm_init_seq #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk(sys_clk), .rst_n(sys_rst_n), .restart_i(restart), .ready_o(ready)
  );

  // Expected period and drift window per code, computed at elaboration.
  logic [CNT_W-1:0] exp_tab [NUM_SLOTS];
  logic [CNT_W-1:0] thr_tab [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_tab
    if (g < NUM_RATIOS) begin : g_used
      localparam int R = ratio_of(g, RATIO_UNIT);
      assign exp_tab[g] = CNT_W'(R);
      assign thr_tab[g] = CNT_W'(DRIFT_BCK * R / BCK_PER_WORD);
    end else begin : g_spare
      assign exp_tab[g] = '0;
      assign thr_tab[g] = '0;
    end
  end

  logic             locked_q, locked_d;
  code_t            code_q, code_d;
  code_t            prev_q, prev_d;
  logic             seen_q, seen_d;
  logic [CNT_W-1:0] expect_cnt, limit_cnt, dev;
  logic             drift;

  assign expect_cnt = exp_tab[code_q];
  assign limit_cnt  = thr_tab[code_q];
  assign dev        = (meas > expect_cnt) ? (meas - expect_cnt) : (expect_cnt - meas);
  assign drift      = dev > limit_cnt;

  always_comb begin
    locked_d = locked_q;
    code_d   = code_q;
    prev_d   = prev_q;
    seen_d   = seen_q;
    restart  = 1'b0;
    if (timeout) begin
      locked_d = 1'b0;
      code_d   = CODE_NONE;
      prev_d   = CODE_NONE;
      seen_d   = 1'b0;
      restart  = locked_q;
    end else if (rise) begin
      if (!seen_q) begin
        seen_d = 1'b1;
        prev_d = CODE_NONE;
      end else if (locked_q) begin
        if (drift) begin
          locked_d = 1'b0;
          code_d   = CODE_NONE;
          prev_d   = CODE_NONE;
          restart  = 1'b1;
        end else begin
          prev_d = cls;
        end
      end else begin
        prev_d = cls;
        if (cls != CODE_NONE && cls == prev_q) begin
          locked_d = 1'b1;
          code_d   = cls;
        end
      end
    end
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      locked_q <= 1'b0;
      code_q   <= CODE_NONE;
      prev_q   <= CODE_NONE;
      seen_q   <= 1'b0;
    end else begin
      locked_q <= locked_d;
      code_q   <= code_d;
      prev_q   <= prev_d;
      seen_q   <= seen_d;
    end
  end

  assign ratio_code     = code_q;
  assign sys_ready      = ready;
  assign ratio_lock     = locked_q;
  assign force_midscale = !ready || !locked_q;

  // R2: lock only rises on a word-clock edge
  a_r2_lock_on_edge: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $rose(ratio_lock) |-> $past(rise));

  // R2: reported code is legal exactly while locked
  a_r2_code_legal_locked: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    ratio_lock |-> (ratio_code < 3'd6));

  a_r2_code_none_unlocked: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !ratio_lock |-> (ratio_code == 3'd7));

  // R5: excessive deviation while locked drops lock and readiness
  a_r5_drift_reinit: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (locked_q && rise && drift) |=> (!ratio_lock && !sys_ready && force_midscale));

  // R7: a silent word clock releases lock
  a_r7_timeout_unlocks: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    timeout |=> !ratio_lock);

endmodule

// File: tb/clk_ratio_sync_mon_tb.sv
`timescale 1ns/1ps
module clk_ratio_sync_mon_tb_top;

  localparam int INIT = 1024;
  localparam int TMO  = 960;
  localparam int TOL  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wclk = 1'b0;
  logic [2:0] code;
  logic       ready, lock, fz;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  clk_ratio_sync_mon dut_i (
    .sys_clk(clk), .sys_rst_n(rst_n), .word_clk(wclk),
    .ratio_code(code), .sys_ready(ready), .ratio_lock(lock), .force_midscale(fz)
  );

  // ---------------- behavioural reference model ----------------
  int rt[$] = '{128, 192, 256, 384, 512, 768};
  int m_code, m_prev, m_cnt, m_init;
  bit m_lock, m_seen, m_ready, m_wq, started;

  function automatic int classify(input int p);
    int c;
    c = 7;
    foreach (rt[i]) if (p >= rt[i] - TOL && p <= rt[i] + TOL) c = i;
    return c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_code = 7; m_prev = 7; m_cnt = 0; m_init = 0;
      m_lock = 0; m_seen = 0; m_ready = 0; m_wq = 0;
      started = 1;
    end else begin
      bit rise, tmo, re;
      int meas, c, d;
      rise = wclk && !m_wq;
      m_wq = wclk;
      tmo  = (m_cnt == TMO) && !rise;
      meas = m_cnt + 1;
      re   = 0;
      if (rise) m_cnt = 0;
      else if (m_cnt != TMO) m_cnt++;
      if (tmo) begin
        re = m_lock;
        m_lock = 0; m_code = 7; m_prev = 7; m_seen = 0;
      end else if (rise) begin
        c = classify(meas);
        if (!m_seen) begin
          m_seen = 1; m_prev = 7;
        end else if (m_lock) begin
          d = meas - rt[m_code];
          if (d < 0) d = -d;
          if (d > 6 * rt[m_code] / 64) begin
            m_lock = 0; m_code = 7; m_prev = 7; re = 1;
          end else m_prev = c;
        end else begin
          if (c != 7 && c == m_prev) begin
            m_lock = 1; m_code = c;
          end
          m_prev = c;
        end
      end
      if (re) begin
        m_init = 0; m_ready = 0;
      end else if (!m_ready) begin
        if (m_init == INIT - 1) m_ready = 1;
        else m_init++;
      end
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s at %0t: got %0d expected %0d", req, $time, got, exp);
    end
  endtask

  // compare against the model away from the active edge
  always @(negedge clk) begin
    if (started) begin
      chk("R1 code", code, m_code);
      chk("R2 lock", lock, m_lock);
      chk("R3 ready", ready, m_ready);
      chk("R4 force", fz, !(m_ready && m_lock));
    end
  end

  task automatic run_periods(input int p, input int n);
    for (int k = 0; k < n; k++) begin
      wclk = 1'b1;
      repeat (p / 2) @(negedge clk);
      wclk = 1'b0;
      repeat (p - p / 2) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired, expected the run to end");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R8: reset state
    chk("R8 code", code, 7);
    chk("R8 ready", ready, 0);
    chk("R8 lock", lock, 0);
    chk("R8 force", fz, 1);
    rst_n = 1'b1;
    // R3: exact window length
    repeat (INIT - 1) @(negedge clk);
    chk("R3 still low", ready, 0);
    @(negedge clk);
    chk("R3 now high", ready, 1);

    // R2: lock at 128
    run_periods(128, 12);
    chk("R2 lock128", lock, 1);
    chk("R1 code128", code, 0);
    chk("R4 released", fz, 0);

    // R5: jump to 768 forces reinit, relock
    run_periods(768, 6);
    chk("R1 code768", code, 5);
    chk("R3 ready768", ready, 1);

    for (int i = 1; i <= 4; i++) begin
      run_periods(rt[i], 8);
      chk("R1 ratio sweep", code, i);
      chk("R2 lock sweep", lock, 1);
    end

    // R6: deviation equal to threshold at 256 (24)
    run_periods(256, 6);
    run_periods(280, 1);
    run_periods(256, 1);
    chk("R6 keep lock", lock, 1);
    chk("R6 keep code", code, 2);
    // R5: one above threshold
    run_periods(281, 1);
    run_periods(256, 1);
    chk("R5 unlock", lock, 0);
    chk("R5 reinit", ready, 0);
    chk("R4 forced", fz, 1);
    run_periods(256, 6);
    chk("R5 relock", lock, 1);

    // R1: invalid ratio never locks
    run_periods(300, 5);
    chk("R1 invalid", code, 7);
    chk("R1 no lock", lock, 0);

    // R1: tolerance edge 136 locks as 128
    run_periods(136, 6);
    chk("R1 tol edge", code, 0);
    // R6: 137 while locked stays locked
    run_periods(137, 3);
    chk("R6 out of class window", lock, 1);

    // R7: stopped word clock
    wclk = 1'b0;
    repeat (1000) @(negedge clk);
    chk("R7 unlock", lock, 0);
    chk("R7 reinit", ready, 0);
    chk("R7 code", code, 7);

    // R1: 137 from unlocked is outside the window
    run_periods(137, 6);
    chk("R1 tol over", lock, 0);
    run_periods(512, 5);
    chk("R1 final", code, 4);

    finish_run();
  end

endmodule